// File: doc/BRIEF.md
# Paged Serial Flash Address Front End

This block sits between a controller that thinks of a serial flash as one flat run of bytes and the flash itself. The flash stores 528 bytes in each page, but its command addresses place every page on a 1024-byte boundary. So a flat byte address must be split into a page number and a byte offset, and the two must be packed as `page * 1024 + offset`. For example, flat address 530 is page 1, offset 2, and goes out as 1026.

A start pulse captures the flat address. A restoring shift-subtract divider then produces the page and offset, taking one cycle per address bit. If the page lies past the last page of the device, the block finishes at once with an error flag and never touches the serial lines. Otherwise it frames a 24-bit command address as an SPI master in mode 0 or mode 3. The address goes out most significant bit first, while the 24 bits arriving on the serial input are collected at the same time. The serial clock runs at the system clock divided by twice a programmable half-period.

Top module: `pfa_front`

## Requirements
- R1: For a flat address A inside the device, the 24 bits shifted out equal `(A / 528) * 1024 + (A mod 528)`. Bits [23:10] carry the page and bits [9:0] carry the offset, most significant bit first. Example: 530 is sent as 1026.
- R2: The offset field of every framed command is below 528.
- R3: A flat address of at least `NUM_PAGES * 528` completes with `err_o` high in the `done_o` cycle. `cs_n_o` never goes low and `rx_data_o` keeps its previous value. `err_o` is never high outside a `done_o` cycle.
- R4: `cs_n_o` is high whenever `busy_o` is low. Within a frame, `cs_n_o` falls exactly H system cycles before the first serial clock edge and rises at least H cycles after the last edge. H is `half_div_i`, with 0 treated as 1.
- R5: A frame has exactly 24 rising and 24 falling serial clock edges, and consecutive edges are H system cycles apart. Outside a frame, `sclk_o` rests at the level of `mode3_i` (low for mode 0, high for mode 3).
- R6: `mosi_o` changes only at falling serial clock edges, or when a frame opens. It is stable at every rising edge.
- R7: `miso_i` is sampled at each rising serial clock edge. The 24 sampled bits, first bit in bit 23, are on `rx_data_o` when `done_o` is high.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The running operation completes with its own address.
- R9: `busy_o` is high from the cycle after an accepted start until the cycle of `done_o`. `done_o` is a one-cycle pulse, during which `busy_o` is low.
- R10: The division ends within `ADDR_W` cycles. An out-of-range request raises `done_o` no later than `ADDR_W + 2` cycles after the start cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse; accepted only when idle |
| lin_addr_i | input | ADDR_W | Flat byte address captured at start |
| half_div_i | input | HDIV_W | Serial clock half-period in system cycles (0 acts as 1) |
| mode3_i | input | 1 | 0: mode 0 (clock rests low), 1: mode 3 (clock rests high) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Address beyond the last page, valid with done |
| rx_data_o | output | 24 | Bits received on the serial input during the last frame |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
Within one serial clock period the block both moves a command bit onto `mosi_o` and captures a bit from `miso_i`. A mis-timed shift register would corrupt one direction while the other still looks right. The bench acts as the flash: it drives a random 24-bit pattern on the serial input at each falling edge and records the serial output at each rising edge. For every frame, it judges the captured command against the computed paged address and `rx_data_o` against the driven pattern, under both modes and several divider values including 0. A second start pulse issued in the middle of a frame is also checked to leave the result of the first request intact.

// File: rtl/pfa_pkg.sv
package pfa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DIVIDE = 2'd1,
        ST_SHIFT  = 2'd2
    } pfa_state_e;

endpackage

// File: rtl/pfa_divider.sv
// Restoring shift-subtract divider by a fixed constant: one quotient bit per cycle.
module pfa_divider #(
    parameter int ADDR_W  = 23,
    parameter int DIVISOR = 528,
    localparam int RW     = $clog2(DIVISOR),
    localparam int CW     = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [ADDR_W-1:0] dividend_i,
    output logic              done_o,
    output logic [ADDR_W-1:0] quot_o,
    output logic [RW-1:0]     rem_o
);

    localparam logic [RW:0]   DIV_C    = (RW + 1)'(DIVISOR);
    localparam logic [CW-1:0] LAST_CNT = CW'(ADDR_W - 1);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [CW-1:0]     cnt;
        logic [ADDR_W-1:0] num;
        logic [ADDR_W-1:0] quot;
        logic [RW-1:0]     rem;
    } div_regs_t;

    div_regs_t r_d, r_q;
    logic [RW:0] trial;
    logic [RW:0] diff;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        trial    = {r_q.rem, r_q.num[ADDR_W-1]};
        diff     = trial - DIV_C;
        if (go_i) begin
            r_d.busy = 1'b1;
            r_d.cnt  = '0;
            r_d.num  = dividend_i;
            r_d.quot = '0;
            r_d.rem  = '0;
        end else if (r_q.busy) begin
            if (trial >= DIV_C) begin
                r_d.rem  = diff[RW-1:0];
                r_d.quot = {r_q.quot[ADDR_W-2:0], 1'b1};
            end else begin
                r_d.rem  = trial[RW-1:0];
                r_d.quot = {r_q.quot[ADDR_W-2:0], 1'b0};
            end
            r_d.num = {r_q.num[ADDR_W-2:0], 1'b0};
            r_d.cnt = r_q.cnt + 1'b1;
            if (r_q.cnt == LAST_CNT) begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done_o = r_q.done;
    assign quot_o = r_q.quot;
    assign rem_o  = r_q.rem;

endmodule

// File: rtl/pfa_spi_shift.sv
// SPI master frame for modes 0 and 3: chip select lead, 2*CMD_W edges, trail.
module pfa_spi_shift #(
    parameter int CMD_W  = 24,
    parameter int HDIV_W = 8,
    localparam int NEDGE = 2 * CMD_W,
    localparam int EW    = $clog2(NEDGE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [HDIV_W-1:0] half_i,
    input  logic              mode3_i,
    input  logic              miso_i,
    output logic              sclk_o,
    output logic              cs_n_o,
    output logic              mosi_o,
    output logic              done_o,
    output logic [CMD_W-1:0]  rx_o
);

    localparam logic [EW-1:0] LAST_EDGE = EW'(NEDGE);

    typedef struct packed {
        logic              active;
        logic [HDIV_W-1:0] half;
        logic [HDIV_W-1:0] tick;
        logic [EW-1:0]     edges;
        logic              sclk;
        logic              cs_n;
        logic              mosi;
        logic              done;
        logic [CMD_W-1:0]  tx;
        logic [CMD_W-1:0]  rx;
    } spi_regs_t;

    spi_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (!r_q.active) begin
            r_d.sclk = mode3_i;
            r_d.cs_n = 1'b1;
            if (go_i) begin
                r_d.active = 1'b1;
                r_d.cs_n   = 1'b0;
                r_d.tx     = cmd_i;
                r_d.mosi   = cmd_i[CMD_W-1];
                r_d.tick   = '0;
                r_d.edges  = '0;
                r_d.half   = (half_i == '0) ? HDIV_W'(1) : half_i;
            end
        end else if (r_q.tick == r_q.half - 1'b1) begin
            r_d.tick = '0;
            if (r_q.edges == LAST_EDGE) begin
                r_d.active = 1'b0;
                r_d.cs_n   = 1'b1;
                r_d.done   = 1'b1;
            end else begin
                r_d.sclk  = ~r_q.sclk;
                r_d.edges = r_q.edges + 1'b1;
                if (!r_q.sclk) begin
                    // rising edge: capture the incoming bit, advance the outgoing one
                    r_d.rx = {r_q.rx[CMD_W-2:0], miso_i};
                    r_d.tx = {r_q.tx[CMD_W-2:0], 1'b0};
                end else begin
                    // falling edge: present the next outgoing bit
                    r_d.mosi = r_q.tx[CMD_W-1];
                end
            end
        end else begin
            r_d.tick = r_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sclk_o = r_q.sclk;
    assign cs_n_o = r_q.cs_n;
    assign mosi_o = r_q.mosi;
    assign done_o = r_q.done;
    assign rx_o   = r_q.rx;

endmodule

// File: rtl/pfa_front.sv
module pfa_front #(
    parameter int ADDR_W     = 23,
    parameter int PAGE_BYTES = 528,
    parameter int NUM_PAGES  = 8192,
    parameter int OFS_W      = 10,
    parameter int CMD_W      = 24,
    parameter int HDIV_W     = 8,
    localparam int PAGE_W    = CMD_W - OFS_W,
    localparam int RW        = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] lin_addr_i,
    input  logic [HDIV_W-1:0] half_div_i,
    input  logic              mode3_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [CMD_W-1:0]  rx_data_o,
    output logic              sclk_o,
    output logic              cs_n_o,
    output logic              mosi_o,
    input  logic              miso_i
);
    import pfa_pkg::*;

    localparam logic [ADDR_W-1:0] PAGE_LIMIT = ADDR_W'(NUM_PAGES);

    typedef struct packed {
        pfa_state_e state;
        logic       done;
        logic       err;
    } top_regs_t;

    top_regs_t r_d, r_q;

    logic              div_go;
    logic              div_done;
    logic [ADDR_W-1:0] div_quot;
    logic [RW-1:0]     div_rem;
    logic              spi_go;
    logic              spi_done;
    logic [CMD_W-1:0]  cmd_word;

    assign cmd_word = {div_quot[PAGE_W-1:0], OFS_W'(div_rem)};

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        div_go   = 1'b0;
        spi_go   = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    div_go    = 1'b1;
                    r_d.state = ST_DIVIDE;
                end
            end
            ST_DIVIDE: begin
                if (div_done) begin
                    if (div_quot >= PAGE_LIMIT) begin
                        r_d.done  = 1'b1;
                        r_d.err   = 1'b1;
                        r_d.state = ST_IDLE;
                    end else begin
                        spi_go    = 1'b1;
                        r_d.state = ST_SHIFT;
                    end
                end
            end
            ST_SHIFT: begin
                if (spi_done) begin
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.done  <= 1'b0;
            r_q.err   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    pfa_divider #(
        .ADDR_W  (ADDR_W),
        .DIVISOR (PAGE_BYTES)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (div_go),
        .dividend_i (lin_addr_i),
        .done_o     (div_done),
        .quot_o     (div_quot),
        .rem_o      (div_rem)
    );

    pfa_spi_shift #(
        .CMD_W  (CMD_W),
        .HDIV_W (HDIV_W)
    ) u_spi (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (spi_go),
        .cmd_i   (cmd_word),
        .half_i  (half_div_i),
        .mode3_i (mode3_i),
        .miso_i  (miso_i),
        .sclk_o  (sclk_o),
        .cs_n_o  (cs_n_o),
        .mosi_o  (mosi_o),
        .done_o  (spi_done),
        .rx_o    (rx_data_o)
    );

    assign busy_o = (r_q.state != ST_IDLE);
    assign done_o = r_q.done;
    assign err_o  = r_q.err;

endmodule

// File: rtl/pfa_front_chk.sv
module pfa_front_chk #(
    parameter int PAGE_BYTES = 528,
    parameter int RW         = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy_o,
    input logic          done_o,
    input logic          err_o,
    input logic          cs_n_o,
    input logic          sclk_o,
    input logic          mosi_o,
    input logic          mode3_i,
    input logic [RW-1:0] ofs
);

    AST_OFS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> (32'(ofs) < PAGE_BYTES));                             // R2

    AST_ERR_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> $past(cs_n_o));                             // R3

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);                                                // R3

    AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> cs_n_o);                                              // R4

    AST_SCLK_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_o && $past(cs_n_o) && !$stable(sclk_o)) |-> (sclk_o == $past(mode3_i))); // R5

    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk_o) && !cs_n_o) |-> $stable(mosi_o));                  // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                              // R9

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);                                              // R9

endmodule

bind pfa_front pfa_front_chk #(
    .PAGE_BYTES (PAGE_BYTES),
    .RW         (RW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .err_o   (err_o),
    .cs_n_o  (cs_n_o),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .mode3_i (mode3_i),
    .ofs     (div_rem)
);

// File: tb/tb_pfa_front.sv
`timescale 1ns/1ps
module tb_pfa_front;

    localparam int ADDR_W = 23;
    localparam int PB     = 528;
    localparam int NP     = 8192;
    localparam int LIMIT  = NP * PB;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] lin_addr_i = '0;
    logic [7:0]        half_div_i = 8'd1;
    logic              mode3_i = 1'b0;
    logic              busy_o, done_o, err_o;
    logic [23:0]       rx_data_o;
    logic              sclk_o, cs_n_o, mosi_o;
    logic              miso_i = 1'b0;

    always #2 clk = ~clk;

    pfa_front dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .lin_addr_i (lin_addr_i),
        .half_div_i (half_div_i), .mode3_i (mode3_i), .busy_o (busy_o),
        .done_o (done_o), .err_o (err_o), .rx_data_o (rx_data_o), .sclk_o (sclk_o),
        .cs_n_o (cs_n_o), .mosi_o (mosi_o), .miso_i (miso_i)
    );

    int total = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_cmd(input int a);
        return ((a / PB) << 10) | (a % PB);
    endfunction

    // flash model / monitor, evaluated away from the active edge
    int          cyc = 0;
    bit          prev_cs = 1'b1;
    bit          prev_sclk = 1'b0;
    int          frames = 0;
    int          rises = 0, falls = 0, edges = 0;
    int          t_csf = 0, t_first = 0, t_last = 0, t_csr = 0;
    int          gap_min = 0, gap_max = 0;
    logic [23:0] cap = '0;
    logic [23:0] cur_pat = '0;
    bit          cur_mode = 1'b0;
    int          midx = 0;
    int          mosi_flips_hi = 0;

    always @(negedge clk) begin
        cyc++;
        if (prev_cs && !cs_n_o) begin
            frames++;
            t_csf = cyc; rises = 0; falls = 0; edges = 0; cap = '0;
            gap_min = 1000000; gap_max = 0;
            miso_i = cur_pat[23];
            midx = cur_mode ? 0 : 1;
        end
        if (!cs_n_o && (sclk_o != prev_sclk)) begin
            if (edges == 0) t_first = cyc;
            else begin
                if (cyc - t_last < gap_min) gap_min = cyc - t_last;
                if (cyc - t_last > gap_max) gap_max = cyc - t_last;
            end
            t_last = cyc;
            edges++;
            if (sclk_o) begin
                rises++;
                cap = {cap[22:0], mosi_o};
            end else begin
                falls++;
                if (midx < 24) miso_i = cur_pat[23 - midx];
                midx++;
            end
        end
        if (!prev_cs && cs_n_o) t_csr = cyc;
        prev_cs   = cs_n_o;
        prev_sclk = sclk_o;
    end

    logic [23:0] last_rx = '0;

    task automatic run(input int a, input bit m3, input logic [7:0] h,
                       input logic [23:0] pat, input bit poke);
        int lat;
        int heff;
        int fr0;
        bit exp_err;
        bit seen;
        heff    = (h == 0) ? 1 : int'(h);
        exp_err = (a >= LIMIT);
        @(negedge clk);
        mode3_i  = m3;
        cur_mode = m3;
        cur_pat  = pat;
        half_div_i = h;
        repeat (2) @(negedge clk);
        chk(sclk_o == m3, "R5", "rest level", sclk_o, m3);
        fr0 = frames;
        lin_addr_i = ADDR_W'(a);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R9", "busy after start", busy_o, 1);
        lat = 1;
        seen = 1'b0;
        while (!seen && lat < 20000) begin
            if (done_o) seen = 1'b1;
            else begin
                if (poke && lat == 40) begin
                    lin_addr_i = '0;
                    start_i = 1'b1;
                end else if (poke && lat == 41) begin
                    start_i = 1'b0;
                    lin_addr_i = ADDR_W'(a);
                end
                @(negedge clk);
                lat++;
            end
        end
        start_i = 1'b0;
        chk(seen, "R9", "done reached (watchdog)", seen, 1);
        if (!seen) return;
        chk(busy_o == 1'b0, "R9", "busy low with done", busy_o, 0);
        chk(err_o == exp_err, "R3", "error flag", err_o, exp_err);
        if (exp_err) begin
            chk(frames == fr0, "R3", "no frame on error", frames - fr0, 0);
            chk(rx_data_o == last_rx, "R3", "rx kept on error", rx_data_o, last_rx);
            chk(lat >= ADDR_W && lat <= ADDR_W + 2, "R10", "error latency", lat, ADDR_W + 2);
        end else begin
            chk(frames == fr0 + 1, poke ? "R8" : "R1", "one frame", frames - fr0, 1);
            chk(cap == 24'(exp_cmd(a)), poke ? "R8" : "R1", "command bits", cap, exp_cmd(a));
            chk(cap[9:0] < 10'd528, "R2", "offset field", cap[9:0], 527);
            chk(rises == 24 && falls == 24, "R5", "edge count", rises + falls, 48);
            chk(gap_min == heff && gap_max == heff, "R5", "edge spacing", gap_max, heff);
            chk(t_first - t_csf == heff, "R4", "select lead", t_first - t_csf, heff);
            chk(t_csr - t_last >= heff, "R4", "select trail", t_csr - t_last, heff);
            chk(rx_data_o == pat, "R7", "received bits", rx_data_o, pat);
            last_rx = rx_data_o;
        end
        @(negedge clk);
        chk(done_o == 1'b0, "R9", "done one cycle", done_o, 0);
        chk(cs_n_o == 1'b1, "R4", "select high idle", cs_n_o, 1);
    endtask

    initial begin
        #(4 * 190000);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int a;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && cs_n_o == 1, "R9", "reset state",
            {busy_o, done_o, cs_n_o}, 3'b001);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n_o == 1'b1 && sclk_o == 1'b0, "R4", "idle after reset", {cs_n_o, sclk_o}, 2'b10);
        // directed corners
        run(530, 1'b0, 8'd2, 24'hA5C3F0, 1'b0);          // R1 example -> 1026
        run(530, 1'b1, 8'd1, 24'h5A0F3C, 1'b0);
        run(0, 1'b0, 8'd0, 24'hFFFFFF, 1'b0);            // zero divider acts as 1
        run(527, 1'b1, 8'd3, 24'h000001, 1'b0);
        run(528, 1'b0, 8'd1, 24'h800000, 1'b0);
        run(LIMIT - 1, 1'b1, 8'd2, 24'h123456, 1'b0);    // last byte
        run(LIMIT, 1'b0, 8'd1, 24'h0, 1'b0);             // R3 first invalid
        run((1 << ADDR_W) - 1, 1'b1, 8'd2, 24'h0, 1'b0); // R3 largest input
        run(3000000, 1'b0, 8'd4, 24'hC0FFEE, 1'b1);      // R8 start while busy
        // constrained random
        for (int i = 0; i < 24; i++) begin
            if ($urandom_range(0, 5) == 0) a = LIMIT + int'($urandom_range(0, 100000));
            else a = int'($urandom_range(0, LIMIT - 1));
            run(a, 1'($urandom_range(0, 1)), 8'($urandom_range(0, 3)),
                24'($urandom), 1'($urandom_range(0, 3) == 0));
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule